// File: doc/BRIEF.md
# Sensor Register Bus Serial Master

This block is the serial master that turns single-register and burst register requests into transactions on a four-wire serial bus. It connects to a sensor whose registers are addressed one byte at a time. A requester supplies four things: a 7-bit start address, a direction, a byte count from 1 to 255 and, for writes, a stream of data bytes. The block lowers chip select and sends one command byte that carries the direction and the address. It then shifts the write bytes out, or it clocks the read bytes in while it drives filler bytes. When the last byte is done it raises chip select again. The sensor advances its register pointer on each byte, so data byte i belongs to register start+i.

The serial clock comes from the system clock through a divider that counts half periods. Two half-period values are available, and the block picks one for each transaction when the request is accepted. The fast value is used only for reads whose whole burst lies inside the sample-data window of the register file. Every other transaction uses the slow value, because the sensor accepts only the slow clock for configuration registers and for writes.

Top module: `sensor_reg_spi`

## Requirements
- R1: The first byte on the data-out line of every transaction is {read flag, address[6:0]}. The read flag is bit 7: 1 for a read, 0 for a write. Every byte is sent MSB first.
- R2: The serial clock is low whenever chip select is high. Data-out changes only while the serial clock is low. Data-in is sampled on the rising edge.
- R3: During the data bytes of a read, the master sends 8'hFF for every byte.
- R4: A read uses the fast half period (FAST_HALF system clocks) when start >= WIN_LO (0x3B) and start + length <= WIN_HI (0x63).
- R5: Every other read, and every write, uses the slow half period (SLOW_HALF system clocks).
- R6: On a write, wr_take pulses once for each data byte, on the cycle in which wr_data is taken. The bytes appear on the bus in the order they were taken, and there are exactly `length` of them.
- R7: On a read, rd_valid pulses exactly `length` times with rd_data. The bytes come in the order they arrived, and no write byte is taken.
- R8: Chip select falls only when a request is accepted. It stays low without a break across the command byte and all `length` data bytes, which is 8*(length+1) serial clock edges. It then rises once.
- R9: busy is high from acceptance until chip select rises. req_ready is low while busy, so requests made then are ignored. done is a one-cycle pulse on the cycle chip select rises.
- R10: After reset, chip select is high, the serial clock is low, busy, done and rd_valid are low, and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | 7 | Start register address |
| req_len | input | 8 | Number of data bytes, 1..255 |
| wr_data | input | 8 | Next write data byte |
| wr_take | output | 1 | wr_data is taken on this cycle |
| rd_data | output | 8 | Received data byte |
| rd_valid | output | 1 | rd_data holds a new byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Pulse when chip select is released |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
A model of the sensor on the bench captures every bit that arrives on a rising edge. It returns a read pattern derived from the address, so an offset, a swapped order or a lost byte all show up as a wrong value. The bench sends single writes and burst writes, including a write inside the sample window. Those cases separate the fast-rate decision from the direction. It sends reads at the exact edges of the window: start 0x3A and 0x3B, end 0x63 and 0x64, and a one-byte read at 0x62. Measuring the clock period on each of these shows which bound is off by one. A request offered during a transfer checks that nothing beyond the first command byte reaches the bus.

// File: rtl/sensor_reg_spi_pkg.sv
package sensor_reg_spi_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_TAIL = 2'd2
  } xfer_state_t;

  // A read qualifies for the fast clock only if the whole burst lies in the window
  function automatic logic rate_is_fast(input logic       rd,
                                        input logic [8:0] first,
                                        input logic [8:0] stop,
                                        input int         lo,
                                        input int         hi);
    return rd && (int'(first) >= lo) && (int'(stop) <= hi);
  endfunction

endpackage

// File: rtl/sensor_reg_spi_div.sv
module sensor_reg_spi_div #(
  parameter int FAST_HALF = 4,
  parameter int SLOW_HALF = 63
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int MAXH = (FAST_HALF > SLOW_HALF) ? FAST_HALF : SLOW_HALF;
  localparam int CW   = (MAXH > 1) ? $clog2(MAXH) : 1;

  logic [CW-1:0] cnt_q, cnt_d, lim;

  assign lim  = fast ? CW'(FAST_HALF - 1) : CW'(SLOW_HALF - 1);
  assign tick = run && (cnt_q == lim);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sensor_reg_spi_shift.sv
module sensor_reg_spi_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          shift,
  input  logic          sample,
  input  logic          miso,
  output logic          mosi,
  output logic [DW-1:0] rx_q
);
  logic [DW-1:0] tx_q, tx_d, rx_d;

  always_comb begin
    tx_d = tx_q;
    if (load)       tx_d = load_val;
    else if (shift) tx_d = {tx_q[DW-2:0], 1'b1};
    rx_d = rx_q;
    if (sample)     rx_d = {rx_q[DW-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '1;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign mosi = tx_q[DW-1];
endmodule

// File: rtl/sensor_reg_spi_ctrl.sv
module sensor_reg_spi_ctrl
  import sensor_reg_spi_pkg::*;
#(
  parameter int DW     = 8,
  parameter int LW     = 8,
  parameter int WIN_LO = 59,
  parameter int WIN_HI = 99
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_read,
  input  logic [DW-2:0] req_addr,
  input  logic [LW-1:0] req_len,
  output logic          req_ready,
  input  logic [DW-1:0] wr_data,
  output logic          wr_take,
  input  logic          tick,
  input  logic [DW-1:0] rx_byte,
  output logic          sh_load,
  output logic [DW-1:0] sh_val,
  output logic          sh_shift,
  output logic          sh_sample,
  output logic          run,
  output logic          fast,
  output logic          sclk,
  output logic          cs_n,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  localparam int AW = DW - 1;
  localparam int BW = $clog2(DW);
  localparam int SW = ((AW > LW) ? AW : LW) + 1;

  xfer_state_t   state_q, state_d;
  logic          sclk_q, sclk_d, cs_n_q, cs_n_d, done_q, done_d;
  logic          rdv_q, rdv_d, rd_q, rd_d, fast_q, fast_d;
  logic [DW-1:0] rdd_q, rdd_d;
  logic [LW-1:0] len_q, len_d, byte_q, byte_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          accept, rise, fall, last_bit, byte_end, more, req_fast;
  logic [SW-1:0] stop_addr;

  assign accept    = req_valid && (state_q == ST_IDLE);
  assign rise      = (state_q == ST_XFER) && tick && !sclk_q;
  assign fall      = (state_q == ST_XFER) && tick && sclk_q;
  assign last_bit  = (bit_q == BW'(DW - 1));
  assign byte_end  = fall && last_bit;
  assign more      = (byte_q != len_q);
  assign stop_addr = SW'(req_addr) + SW'(req_len);
  assign req_fast  = rate_is_fast(req_read, 9'(req_addr), 9'(stop_addr), WIN_LO, WIN_HI);

  assign wr_take   = byte_end && more && !rd_q;
  assign sh_load   = accept || (byte_end && more);
  assign sh_val    = accept ? {req_read, req_addr} : (rd_q ? {DW{1'b1}} : wr_data);
  assign sh_shift  = fall && !last_bit;
  assign sh_sample = rise;

  always_comb begin
    state_d = state_q;
    sclk_d  = sclk_q;
    cs_n_d  = cs_n_q;
    done_d  = 1'b0;
    rdv_d   = 1'b0;
    rdd_d   = rdd_q;
    rd_d    = rd_q;
    fast_d  = fast_q;
    len_d   = len_q;
    byte_d  = byte_q;
    bit_d   = bit_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_XFER;
          cs_n_d  = 1'b0;
          rd_d    = req_read;
          fast_d  = req_fast;
          len_d   = req_len;
          byte_d  = '0;
          bit_d   = '0;
        end
      end
      ST_XFER: begin
        if (rise) sclk_d = 1'b1;
        if (fall) begin
          sclk_d = 1'b0;
          if (last_bit) begin
            bit_d = '0;
            if (rd_q && (byte_q != '0)) begin
              rdv_d = 1'b1;
              rdd_d = rx_byte;
            end
            if (more) byte_d = byte_q + LW'(1);
            else      state_d = ST_TAIL;
          end else begin
            bit_d = bit_q + BW'(1);
          end
        end
      end
      ST_TAIL: begin
        if (tick) begin
          state_d = ST_IDLE;
          cs_n_d  = 1'b1;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
      rdv_q   <= 1'b0;
      rdd_q   <= '0;
      rd_q    <= 1'b0;
      fast_q  <= 1'b0;
      len_q   <= '0;
      byte_q  <= '0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      sclk_q  <= sclk_d;
      cs_n_q  <= cs_n_d;
      done_q  <= done_d;
      rdv_q   <= rdv_d;
      rdd_q   <= rdd_d;
      rd_q    <= rd_d;
      fast_q  <= fast_d;
      len_q   <= len_d;
      byte_q  <= byte_d;
      bit_q   <= bit_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign run       = busy;
  assign fast      = fast_q;
  assign sclk      = sclk_q;
  assign cs_n      = cs_n_q;
  assign done      = done_q;
  assign rd_data   = rdd_q;
  assign rd_valid  = rdv_q;
endmodule

// File: rtl/sensor_reg_spi.sv
module sensor_reg_spi #(
  parameter int FAST_HALF = 4,
  parameter int SLOW_HALF = 63,
  parameter int WIN_LO    = 59,
  parameter int WIN_HI    = 99
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_read,
  input  logic [6:0] req_addr,
  input  logic [7:0] req_len,
  input  logic [7:0] wr_data,
  output logic       wr_take,
  output logic [7:0] rd_data,
  output logic       rd_valid,
  output logic       busy,
  output logic       done,
  output logic       spi_sclk,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  localparam int DW = 8;
  localparam int LW = 8;

  logic          tick, run, fast, sh_load, sh_shift, sh_sample;
  logic [DW-1:0] sh_val, rx_byte;

  sensor_reg_spi_div #(.FAST_HALF(FAST_HALF), .SLOW_HALF(SLOW_HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .fast(fast), .tick(tick)
  );

  sensor_reg_spi_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(sh_val),
    .shift(sh_shift), .sample(sh_sample), .miso(spi_miso),
    .mosi(spi_mosi), .rx_q(rx_byte)
  );

  sensor_reg_spi_ctrl #(.DW(DW), .LW(LW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_read(req_read), .req_addr(req_addr),
    .req_len(req_len), .req_ready(req_ready),
    .wr_data(wr_data), .wr_take(wr_take),
    .tick(tick), .rx_byte(rx_byte),
    .sh_load(sh_load), .sh_val(sh_val), .sh_shift(sh_shift), .sh_sample(sh_sample),
    .run(run), .fast(fast), .sclk(spi_sclk), .cs_n(spi_cs_n),
    .busy(busy), .done(done), .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/sensor_reg_spi_checker.sv
module sensor_reg_spi_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic done,
  input logic rd_valid,
  input logic wr_take,
  input logic spi_sclk,
  input logic spi_cs_n,
  input logic spi_mosi
);
  p_idle_sclk_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  p_cs_on_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(req_valid && req_ready));

  p_done_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> done);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_cs_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n);

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !wr_take);
endmodule

bind sensor_reg_spi sensor_reg_spi_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .done(done), .rd_valid(rd_valid), .wr_take(wr_take),
  .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
);

// File: tb/sensor_reg_spi_bench.sv
module sensor_reg_spi_bench;
  localparam int FH = 4;
  localparam int SH = 63;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_ready, req_read;
  logic [6:0] req_addr;
  logic [7:0] req_len, wr_data, rd_data;
  logic       wr_take, rd_valid, busy, done;
  logic       spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  always #4 clk = ~clk;

  sensor_reg_spi #(.FAST_HALF(FH), .SLOW_HALF(SH), .WIN_LO(59), .WIN_HI(99)) u_sensor_reg_spi (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_read(req_read), .req_addr(req_addr), .req_len(req_len),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .busy(busy), .done(done), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // ---- sensor model ----
  int         s_bits = 0;
  int         cs_falls = 0;
  logic [7:0] s_in = 8'h00;
  logic [7:0] s_cmd = 8'h00;
  logic [7:0] s_rx [0:255];
  logic [7:0] resp;

  always @(posedge spi_sclk or negedge spi_cs_n) begin
    if (!spi_cs_n && spi_sclk) begin
      s_in = {s_in[6:0], spi_mosi};
      s_bits++;
      if (s_bits % 8 == 0) begin
        if (s_bits == 8) s_cmd = s_in;
        else             s_rx[(s_bits / 8 - 2) % 256] = s_in;
      end
    end else if (!spi_cs_n) begin
      s_bits = 0;
      cs_falls++;
    end
  end

  assign resp     = ({1'b0, s_cmd[6:0]} + 8'(s_bits / 8 - 1)) ^ 8'h5A;
  assign spi_miso = (s_bits < 8) ? 1'b0 : resp[3'(7 - (s_bits % 8))];

  // ---- write data source ----
  logic [7:0] wr_arr [0:255];
  int         wr_cnt = 0;
  int         wr_base = 0;
  always @(posedge clk) if (wr_take) wr_cnt <= wr_cnt + 1;
  assign wr_data = wr_arr[(wr_cnt - wr_base) % 256];

  // ---- output monitors ----
  int         cyc = 0, last_rise = -1, pmin = 0, pmax = 0;
  int         rd_total = 0, done_cnt = 0;
  logic [7:0] rd_log [0:1023];
  logic       sclk_prev = 1'b0, cs_prev = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (rd_valid) begin
      rd_log[rd_total % 1024] = rd_data;
      rd_total++;
    end
    if (done) done_cnt++;
    if (cs_prev && !spi_cs_n) begin
      pmin = 1 << 30;
      pmax = 0;
      last_rise = -1;
    end
    if (spi_sclk && !sclk_prev) begin
      if (last_rise >= 0) begin
        if (cyc - last_rise < pmin) pmin = cyc - last_rise;
        if (cyc - last_rise > pmax) pmax = cyc - last_rise;
      end
      last_rise = cyc;
    end
    sclk_prev = spi_sclk;
    cs_prev   = spi_cs_n;
  end

  // ---- watchdog ----
  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
    $finish;
  end

  // One transaction with full checking; poke offers a second request while busy
  task automatic do_txn(input bit rd, input logic [6:0] a, input int n, input bit poke);
    int  cf0, d0, r0, w0, exp_per, bad, first_bad_a, first_bad_e;
    bit  fast_exp;
    for (int k = 0; k < n; k++) wr_arr[k] = 8'(a * 7 + k * 13 + 1);
    fast_exp = rd && (int'(a) >= 59) && (int'(a) + n <= 99);
    cf0 = cs_falls; d0 = done_cnt; r0 = rd_total; w0 = wr_cnt;
    wr_base = w0;
    @(negedge clk);
    req_valid = 1'b1; req_read = rd; req_addr = a; req_len = 8'(n);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R9", "busy after accept", int'(busy), 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      req_valid = 1'b1; req_read = 1'b0; req_addr = 7'h00; req_len = 8'd1;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk(req_ready == 1'b0, "R9", "ready while busy", int'(req_ready), 0);
      end
      req_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R9", "cs released with done", int'(spi_cs_n), 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9", "done pulse ends, idle", int'({done, busy}), 0);
    repeat (4) @(negedge clk);
    chk(done_cnt - d0 == 1, "R9", "done pulses", done_cnt - d0, 1);
    chk(cs_falls - cf0 == 1, "R8", "chip select windows", cs_falls - cf0, 1);
    chk(s_bits == 8 * (n + 1), "R8", "clock edges in window", s_bits, 8 * (n + 1));
    chk(s_cmd == {rd, a}, "R1", "command byte", int'(s_cmd), int'({rd, a}));
    chk(spi_sclk == 1'b0 && spi_cs_n == 1'b1, "R2", "idle clock low", int'(spi_sclk), 0);
    exp_per = fast_exp ? 2 * FH : 2 * SH;
    chk(pmin == exp_per && pmax == exp_per, fast_exp ? "R4" : "R5",
        "clock period", (pmin == exp_per) ? pmax : pmin, exp_per);
    bad = 0; first_bad_a = 0; first_bad_e = 0;
    if (rd) begin
      for (int k = 0; k < n; k++) if (s_rx[k] != 8'hFF && bad++ == 0) begin
        first_bad_a = int'(s_rx[k]); first_bad_e = 8'hFF;
      end
      chk(bad == 0, "R3", "filler bytes", first_bad_a, first_bad_e);
      chk(rd_total - r0 == n, "R7", "read strobes", rd_total - r0, n);
      bad = 0;
      for (int k = 0; k < n; k++) begin
        logic [7:0] e;
        e = (8'(a) + 8'(k)) ^ 8'h5A;
        if (rd_log[(r0 + k) % 1024] != e && bad++ == 0) begin
          first_bad_a = int'(rd_log[(r0 + k) % 1024]); first_bad_e = int'(e);
        end
      end
      chk(bad == 0, "R7", "read data order", first_bad_a, first_bad_e);
      chk(wr_cnt == w0, "R7", "no write take on read", wr_cnt - w0, 0);
    end else begin
      for (int k = 0; k < n; k++) if (s_rx[k] != wr_arr[k] && bad++ == 0) begin
        first_bad_a = int'(s_rx[k]); first_bad_e = int'(wr_arr[k]);
      end
      chk(bad == 0, "R6", "write bytes on bus", first_bad_a, first_bad_e);
      chk(wr_cnt - w0 == n, "R6", "write takes", wr_cnt - w0, n);
      chk(rd_total == r0, "R6", "no read strobe on write", rd_total - r0, 0);
    end
  endtask

  task automatic t_reset;
    chk(spi_cs_n == 1'b1, "R10", "reset cs_n", int'(spi_cs_n), 1);
    chk(spi_sclk == 1'b0, "R10", "reset sclk", int'(spi_sclk), 0);
    chk(busy == 1'b0 && done == 1'b0 && rd_valid == 1'b0, "R10", "reset flags",
        int'({busy, done, rd_valid}), 0);
    chk(req_ready == 1'b1, "R10", "reset ready", int'(req_ready), 1);
  endtask

  task automatic t_writes;
    do_txn(1'b0, 7'h6B, 1, 1'b0);
    do_txn(1'b0, 7'h1A, 3, 1'b0);
    do_txn(1'b0, 7'h3B, 2, 1'b0);   // R5: write inside window stays slow
    do_txn(1'b0, 7'h10, 16, 1'b0);
  endtask

  task automatic t_reads_slow;
    do_txn(1'b1, 7'h75, 1, 1'b0);
    do_txn(1'b1, 7'h3A, 1, 1'b0);   // R5: starts below window
    do_txn(1'b1, 7'h3B, 41, 1'b0);  // R5: ends one past window
  endtask

  task automatic t_reads_fast;
    do_txn(1'b1, 7'h3B, 14, 1'b0);  // R4
    do_txn(1'b1, 7'h3B, 40, 1'b0);  // R4: ends exactly at bound
    do_txn(1'b1, 7'h62, 1, 1'b0);   // R4: last byte in window
  endtask

  task automatic t_busy_block;
    do_txn(1'b1, 7'h41, 2, 1'b1);   // R9: second request ignored
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_read = 1'b0; req_addr = '0; req_len = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_writes;
    t_reads_slow;
    t_reads_fast;
    t_busy_block;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule